// File: doc/BRIEF.md
# Dual-Timing FIFO with Rewind

A single-clock FIFO controller whose output timing is chosen while the master reset is held. In standard timing the reader asks for a word and gets it on the next clock, guarded by `empty_o` and `full_o`. In fall-through timing the oldest word moves to the output by itself and is flagged by `out_valid_o`. The output register then counts as one more storage slot, so the FIFO takes DEPTH+1 words before `in_ready_o` drops. A half-full flag follows the occupancy against the capacity of the active timing.

A rewind request (`rt_i`) moves the read side back to the first word written since the last reset. The stored contents can then be read again, for example to resend a frame after an error. This works as long as no more than DEPTH words have been written since that reset. A partial reset (`prst_i`) drops all stored words but keeps the timing mode. The asynchronous master reset (`rst_ni`) clears all state and loads the mode from `fwft_sel_i`.

Top module: `dmf_fifo`

## Requirements
- R1: The mode is taken from `fwft_sel_i` (1 = fall-through, 0 = standard) only while `rst_ni` is low. Changing `fwft_sel_i` later has no effect, and this includes the clock on which a partial reset is applied.
- R2: In standard mode `empty_o` is high when the FIFO holds no words, and `full_o` is high when it holds DEPTH words. A read accepted on one clock places the oldest word on `rd_data_o` after that edge.
- R3: In standard mode a write while `full_o` is high, and a read while `empty_o` is high, are ignored. A read while empty leaves `rd_data_o` unchanged. A read and a write on the same clock are both accepted when the FIFO is neither empty nor full.
- R4: In fall-through mode a word written into an empty FIFO appears on `rd_data_o`, with `out_valid_o` high, after the second rising edge that follows the write. No read request is needed.
- R5: In fall-through mode `in_ready_o` goes low once DEPTH+1 words are held, and writes while it is low are ignored.
- R6: In fall-through mode a read while `out_valid_o` is high removes the shown word and brings up the next one without a gap. A read while `out_valid_o` is low is ignored.
- R7: `half_o` is high when the words held, times 2, exceed DEPTH in standard mode or DEPTH+1 in fall-through mode.
- R8: In standard mode a rewind makes the FIFO hold every word written since the last reset, oldest first, and the flags follow that count on the next clock. Write and read requests on the rewind clock are ignored.
- R9: In fall-through mode a rewind shows the first word written since the last reset on `rd_data_o`, with `out_valid_o` high, right after the rewind edge.
- R10: A partial reset empties the FIFO, clears `half_o` and `full_o`, clears `out_valid_o`, and drives `rd_data_o` to zero. It takes priority over a rewind.
- R11: Master reset clears every word and flag asynchronously. After it, standard mode shows `empty_o` high and fall-through mode shows `in_ready_o` high.
- R12: The flags of the inactive mode stay low: `out_valid_o` and `in_ready_o` in standard mode, `empty_o` and `full_o` in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous master reset, active low; loads the mode |
| fwft_sel_i | input | 1 | Mode select sampled during master reset: 1 = fall-through |
| prst_i | input | 1 | Synchronous partial reset, active high |
| rt_i | input | 1 | Rewind request, active high |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | WIDTH | Output data register |
| empty_o | output | 1 | Standard mode: no words held |
| full_o | output | 1 | Standard mode: DEPTH words held |
| out_valid_o | output | 1 | Fall-through mode: `rd_data_o` holds a valid word |
| in_ready_o | output | 1 | Fall-through mode: a write will be accepted |
| half_o | output | 1 | More than half of the mode's capacity is in use |

## Verification
The bench drives both modes to their limits. It fills past DEPTH in standard mode and past DEPTH+1 in fall-through mode, and a design that took the extra write would overwrite the oldest word and return corrupt data. It reads past empty and checks that the output register keeps its value. It rewinds with write and read requests active on the same clock, and a controller that honoured those requests would lose or duplicate a word in the replay. A fall-through rewind that waited a clock before reloading the output would show a one-cycle drop of `out_valid_o`. The bench also changes the mode select without a master reset, to catch a mode register that is loaded on partial reset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } dmf_mode_e;
endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CW    = 11
) (
  input  logic          fwft_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ov_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          out_valid_o,
  output logic          in_ready_o,
  output logic          half_o
);
  localparam logic [CW-1:0] CAP_STD  = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_FWFT = CW'(DEPTH + 1);

  logic [CW-1:0] total;
  logic [CW:0]   twice;

  // output register counts as storage only in fall-through timing
  assign total = cnt_i + CW'(fwft_i & ov_i);
  assign twice = {total, 1'b0};

  always_comb begin
    empty_o     = 1'b0;
    full_o      = 1'b0;
    out_valid_o = 1'b0;
    in_ready_o  = 1'b0;
    if (fwft_i) begin
      out_valid_o = ov_i;
      in_ready_o  = total != CAP_FWFT;
      half_o      = twice > {1'b0, CAP_FWFT};
    end else begin
      empty_o = total == '0;
      full_o  = total == CAP_STD;
      half_o  = twice > {1'b0, CAP_STD};
    end
  end
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned WIDTH = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwft_sel_i,
  input  logic             prst_i,
  input  logic             rt_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             out_valid_o,
  output logic             in_ready_o,
  output logic             half_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 2);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [CW-1:0] D_CNT  = CW'(DEPTH);
  localparam logic [CW-1:0] T_SAT  = CW'(DEPTH + 1);

  dmf_mode_e        mode_q;
  logic [AW-1:0]    wptr_q, rptr_q, rd_addr;
  logic [CW-1:0]    cnt_q, cnt_d, wtot_q;
  logic             ov_q;
  logic [WIDTH-1:0] out_q, rd_word;

  logic is_fwft, normal, arr_empty, arr_full;
  logic do_wr, pop_out, do_load, do_rd_std, arr_pop, rt_has;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign is_fwft   = mode_q == MODE_FWFT;
  assign normal    = !prst_i && !rt_i;
  assign arr_empty = cnt_q == '0;
  assign arr_full  = cnt_q == D_CNT;
  assign do_wr     = normal && wr_en_i && !arr_full;
  assign pop_out   = is_fwft && rd_en_i && ov_q;
  assign do_load   = is_fwft && !arr_empty && (!ov_q || pop_out);
  assign do_rd_std = !is_fwft && rd_en_i && !arr_empty;
  assign arr_pop   = normal && (do_load || do_rd_std);
  assign rt_has    = wtot_q != '0;
  // rewind reads location zero directly so the output reloads on the same edge
  assign rd_addr   = rt_i ? '0 : rptr_q;

  always_comb begin
    unique case ({do_wr, arr_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  dmf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) i_store (
    .clk_i  (clk_i),
    .we_i   (do_wr),
    .waddr_i(wptr_q),
    .wdata_i(wr_data_i),
    .raddr_i(rd_addr),
    .rdata_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      wtot_q <= '0;
      ov_q   <= 1'b0;
      out_q  <= '0;
    end else if (prst_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      wtot_q <= '0;
      ov_q   <= 1'b0;
      out_q  <= '0;
    end else if (rt_i) begin
      if (is_fwft && rt_has) begin
        rptr_q <= step('0);
        cnt_q  <= wtot_q - CW'(1);
        ov_q   <= 1'b1;
        out_q  <= rd_word;
      end else begin
        rptr_q <= '0;
        cnt_q  <= wtot_q;
        ov_q   <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_d;
      if (do_wr) begin
        wptr_q <= step(wptr_q);
        if (wtot_q != T_SAT) wtot_q <= wtot_q + CW'(1);
      end
      if (arr_pop) begin
        rptr_q <= step(rptr_q);
        out_q  <= rd_word;
      end
      if (is_fwft) ov_q <= do_load || (ov_q && !pop_out);
    end
  end

  assign rd_data_o = out_q;

  dmf_flags #(.DEPTH(DEPTH), .CW(CW)) i_flags (
    .fwft_i     (is_fwft),
    .cnt_i      (cnt_q),
    .ov_i       (ov_q),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .out_valid_o(out_valid_o),
    .in_ready_o (in_ready_o),
    .half_o     (half_o)
  );
endmodule

// File: rtl/dmf_fifo_chk.sv
module dmf_fifo_chk #(
  parameter int unsigned WIDTH = 36
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fwft_i,
  input logic             prst_i,
  input logic             rt_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             out_valid_o,
  input logic             in_ready_o,
  input logic             half_o
);
  // R3
  std_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft_i && full_o && wr_en_i && !rd_en_i && !rt_i && !prst_i) |=> full_o);

  // R3
  std_empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft_i && empty_o && rd_en_i && !wr_en_i && !rt_i && !prst_i)
      |=> (empty_o && $stable(rd_data_o)));

  // R6
  fwft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && out_valid_o && !rd_en_i && !rt_i && !prst_i)
      |=> (out_valid_o && $stable(rd_data_o)));

  // R5
  fwft_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && !in_ready_o && wr_en_i && !rd_en_i && !rt_i && !prst_i) |=> !in_ready_o);

  // R10
  prst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i |=> (!half_o && !full_o && !out_valid_o && rd_data_o == '0));

  // R12
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((empty_o || full_o) && (out_valid_o || in_ready_o)));

  // R7
  half_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> !empty_o);
endmodule

bind dmf_fifo dmf_fifo_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fwft_i     (is_fwft),
  .prst_i     (prst_i),
  .rt_i       (rt_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .out_valid_o(out_valid_o),
  .in_ready_o (in_ready_o),
  .half_o     (half_o)
);

// File: tb/test_dmf_fifo.sv
`timescale 1ns/1ps
module test_dmf_fifo;
  localparam int D = 16;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni, fwft_sel, prst, rt, wr_en, rd_en;
  logic [W-1:0] wr_data, rd_data;
  logic         empty, full, out_valid, in_ready, half;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    started = 1'b0;
  string tag = "R11";

  dmf_fifo #(.DEPTH(D), .WIDTH(W)) i_dmf_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .fwft_sel_i(fwft_sel), .prst_i(prst), .rt_i(rt),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .empty_o(empty), .full_o(full), .out_valid_o(out_valid), .in_ready_o(in_ready),
    .half_o(half)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  logic [W-1:0] q[$];
  logic [W-1:0] hist[$];
  bit           m_fwft, m_ov;
  logic [W-1:0] m_out;

  task automatic check(string req, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s/%s %s: got %h expected %h at %0t", req, tag, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int n;
    bit pop, load;
    if (!rst_ni) begin
      q.delete(); hist.delete(); m_ov = 0; m_out = '0; m_fwft = fwft_sel;
    end else if (prst) begin
      q.delete(); hist.delete(); m_ov = 0; m_out = '0;
    end else if (rt) begin
      q.delete();
      if (!m_fwft) begin
        foreach (hist[i]) q.push_back(hist[i]);
      end else if (hist.size() > 0) begin
        m_out = hist[0]; m_ov = 1;
        for (int i = 1; i < hist.size(); i++) q.push_back(hist[i]);
      end else m_ov = 0;
    end else if (!m_fwft) begin
      n = q.size();
      if (rd_en && n > 0) m_out = q.pop_front();
      if (wr_en && n < D) begin q.push_back(wr_data); hist.push_back(wr_data); end
    end else begin
      n = q.size();
      pop  = rd_en && m_ov;
      load = (n > 0) && (!m_ov || pop);
      if (load) m_out = q.pop_front();
      m_ov = load || (m_ov && !pop);
      if (wr_en && n < D) begin q.push_back(wr_data); hist.push_back(wr_data); end
    end
    #2;
    if (started) begin
      int tot;
      tot = q.size() + (m_fwft ? int'(m_ov) : 0);
      if (!m_fwft) begin
        check("R2", "empty_o", W'(empty), W'(tot == 0));
        check("R2", "full_o", W'(full), W'(tot == D));
        check("R12", "out_valid_o", W'(out_valid), '0);
        check("R12", "in_ready_o", W'(in_ready), '0);
        check("R7", "half_o", W'(half), W'(2 * tot > D));
        check("R2", "rd_data_o", rd_data, m_out);
      end else begin
        check("R12", "empty_o", W'(empty), '0);
        check("R12", "full_o", W'(full), '0);
        check("R4", "out_valid_o", W'(out_valid), W'(m_ov));
        check("R5", "in_ready_o", W'(in_ready), W'(tot <= D));
        check("R7", "half_o", W'(half), W'(2 * tot > D + 1));
        if (m_ov) check("R6", "rd_data_o", rd_data, m_out);
      end
    end
  end

  task automatic op(bit w, logic [W-1:0] d, bit r, bit t = 0, bit p = 0);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; rt = t; prst = p;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, '0, 0);
  endtask

  task automatic reset_to(bit f);
    @(negedge clk);
    wr_en = 0; rd_en = 0; rt = 0; prst = 0;
    fwft_sel = f; rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired tag %s", tag);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b1; fwft_sel = 0; prst = 0; rt = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    #1 rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    started = 1'b1;

    // standard timing
    tag = "R11"; reset_to(0); idle(2);
    tag = "R2";  for (int i = 0; i < D; i++) op(1, W'(16'h0100 + i), 0);
    tag = "R3";  op(1, 16'hdead, 0); op(1, 16'hbeef, 0); idle(1);
    tag = "R2";  for (int i = 0; i < 3; i++) op(0, '0, 1);
    op(1, 16'h0200, 1); op(1, 16'h0201, 1);
    tag = "R3";  for (int i = 0; i < D + 2; i++) op(0, '0, 1);
    idle(1);
    tag = "R1";  fwft_sel = 1; op(1, 16'h0210, 0); op(1, 16'h0211, 0); idle(3);
    op(0, '0, 1);
    tag = "R10"; op(0, '0, 0, 1, 1); idle(2);
    tag = "R1";  op(1, 16'h0220, 0); idle(3);
    tag = "R10"; op(0, '0, 0, 0, 1); idle(1);
    tag = "R8";  for (int i = 0; i < 5; i++) op(1, W'(16'h0300 + i), 0);
    op(0, '0, 1); op(0, '0, 1);
    op(1, 16'h0bad, 1, 1, 0); idle(1);
    for (int i = 0; i < 6; i++) op(0, '0, 1);
    idle(1);

    // fall-through timing
    tag = "R11"; reset_to(1); idle(2);
    tag = "R4";  op(1, 16'h0400, 0); idle(3);
    tag = "R6";  op(0, '0, 1); op(0, '0, 1); idle(1);
    tag = "R5";  for (int i = 0; i < D + 1; i++) op(1, W'(16'h0500 + i), 0);
    op(1, 16'hdead, 0); op(1, 16'hbeef, 0); idle(2);
    tag = "R6";  for (int i = 0; i < 4; i++) op(0, '0, 1);
    op(1, 16'h0600, 1); op(0, '0, 0);
    for (int i = 0; i < D + 2; i++) op(0, '0, 1);
    idle(1);
    tag = "R10"; op(1, 16'h0777, 1, 1, 1); idle(1);
    tag = "R9";  for (int i = 0; i < 4; i++) op(1, W'(16'h0700 + i), 0);
    idle(2); op(0, '0, 1); op(0, '0, 1);
    op(1, 16'h0bad, 1, 1, 0);
    for (int i = 0; i < 5; i++) op(0, '0, 1);
    idle(1);
    tag = "R1";  fwft_sel = 0; op(0, '0, 0, 0, 1); op(1, 16'h0800, 0); idle(3);

    tag = "R11"; reset_to(0); idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule